// File: doc/BRIEF.md
# Configuration Register File with I2C Target Access

This block is an I2C target that owns a small bank of six eight-bit configuration registers. A controller on the two-wire bus addresses it with the fixed 7-bit address 0010011. A write transfer first loads an internal register pointer and then stores any number of data bytes. A read transfer streams bytes out from the pointer. The pointer advances after every byte in either direction and is shared by both directions. A current-address read therefore picks up one past the last register touched.

A fast system clock samples SCL and SDA through synchroniser flops. The block pulls SDA low through an open-drain enable and never drives it high. The six registers appear as one flat parallel output bus, with register n at bits 8n+7:8n, for the logic they configure. An asynchronous active-low power-down input returns every register to its reset value and drops any transfer in progress.

Top module: `i2cCfgRegs`

## Requirements
- R1: After power-down the registers hold 00h=32h, 01h=A1h, 02h=3Eh, 03h=3Eh, 04h=FFh, 05h=09h, and SDA is released.
- R2: Only a header whose top seven bits equal 0010011 is acknowledged. Bit 0 of the header selects the direction (1 read, 0 write). Any other address gets no acknowledge and changes no register.
- R3: In a write, the first byte after the header sets the pointer from its low five bits, and its top three bits are ignored. Each later data byte is acknowledged and stored at the pointer.
- R4: The pointer advances by one after every data byte, written or read, and wraps from 05h to 00h.
- R5: Reserved bits always read 0 and ignore writes: bits 3:2 of 00h, bits 6, 3 and 1 of 01h, and bits 7:4 of 05h.
- R6: A read with no pointer byte starts at one past the last register accessed by a read or a write.
- R7: A write of the pointer, a repeated START and a read header together read from the chosen pointer.
- R8: During a read the target sends another byte each time the controller acknowledges. After a not-acknowledge it keeps SDA released until a STOP.
- R9: Data bytes written at pointers 06h to 1Fh are acknowledged and discarded. Reads at those pointers return 00h, and the pointer rolls from 1Fh to 00h.
- R10: Asserting power-down in the middle of a transfer reloads every register at once, without waiting for a clock edge.
- R11: START is SDA falling and STOP is SDA rising while SCL is high. A START seen mid-byte abandons that byte and restarts header reception.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System sampling clock |
| pwrDownN | input | 1 | Asynchronous active-low power-down, reloads defaults |
| sclIn | input | 1 | Bus clock line as seen at the pin |
| sdaIn | input | 1 | Bus data line as seen at the pin |
| sdaDrvLow | output | 1 | Open-drain enable: 1 pulls SDA low |
| regOut | output | 48 | Register contents, register n at bits 8n+7:8n |

## Verification
The bench builds the block with its default parameters: six registers, a five-bit pointer, address 0010011 and two synchroniser stages. With six registers the 05h-to-00h wrap takes only a few bytes in either direction. With a five-bit pointer the unmapped pointers 06h to 1Fh, and the natural roll from 1Fh to 00h, can be reached directly. The two-stage synchroniser, with a bus bit lasting 24 system clocks, leaves margin for the target's drive changes to settle well inside each SCL low phase.

// File: rtl/cfgI2cPkg.sv
package cfgI2cPkg;

  typedef enum logic [3:0] {
    ST_IDLE, ST_HDR, ST_HDR_ACK, ST_PTR, ST_PTR_ACK,
    ST_WDATA, ST_WDATA_ACK, ST_TX, ST_TX_ACK, ST_WAIT
  } ctrlState_e;

  // strobes from the bus control to the register datapath
  typedef struct packed {
    logic       setPtr;
    logic       wrEn;
    logic       rdAdv;
    logic [7:0] byteVal;
  } regStrobe_t;

  function automatic logic [7:0] regDefault(input int idx);
    case (idx)
      0: return 8'h32;
      1: return 8'hA1;
      2: return 8'h3E;
      3: return 8'h3E;
      4: return 8'hFF;
      5: return 8'h09;
      default: return 8'h00;
    endcase
  endfunction

  // writable bit mask per register; cleared bits are reserved
  function automatic logic [7:0] regMask(input int idx);
    case (idx)
      0: return 8'hF3;
      1: return 8'hB5;
      2, 3, 4: return 8'hFF;
      5: return 8'h0F;
      default: return 8'h00;
    endcase
  endfunction

endpackage

// File: rtl/cfgI2cCtrl.sv
module cfgI2cCtrl
  import cfgI2cPkg::*;
#(
  parameter logic [6:0] DEV_ADDR    = 7'h13,
  parameter int         SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       pwrDownN,
  input  logic       sclIn,
  input  logic       sdaIn,
  input  logic [7:0] rdData,
  output logic       sdaDrvLow,
  output regStrobe_t stb
);

  logic [SYNC_STAGES-1:0] sclSync, sdaSync;
  logic sclPrev, sdaPrev;
  logic sclS, sdaS;
  logic sclRise, sclFall, startDet, stopDet;

  ctrlState_e state;
  logic [3:0] bitCnt;
  logic [7:0] shiftIn, txShift;
  logic       rwBit, mAck, driveLow;

  always_ff @(posedge clk or negedge pwrDownN) begin
    if (!pwrDownN) begin
      sclSync <= '1;
      sdaSync <= '1;
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclSync <= {sclSync[SYNC_STAGES-2:0], sclIn};
      sdaSync <= {sdaSync[SYNC_STAGES-2:0], sdaIn};
      sclPrev <= sclS;
      sdaPrev <= sdaS;
    end
  end

  assign sclS     = sclSync[SYNC_STAGES-1];
  assign sdaS     = sdaSync[SYNC_STAGES-1];
  assign sclRise  = sclS & ~sclPrev;
  assign sclFall  = ~sclS & sclPrev;
  assign startDet = sclS & sclPrev & sdaPrev & ~sdaS;
  assign stopDet  = sclS & sclPrev & ~sdaPrev & sdaS;

  always_ff @(posedge clk or negedge pwrDownN) begin
    if (!pwrDownN) begin
      state    <= ST_IDLE;
      bitCnt   <= '0;
      shiftIn  <= '0;
      txShift  <= '0;
      rwBit    <= 1'b0;
      mAck     <= 1'b0;
      driveLow <= 1'b0;
      stb      <= '0;
    end else begin
      stb <= '0;
      if (startDet) begin
        state    <= ST_HDR;
        bitCnt   <= '0;
        driveLow <= 1'b0;
      end else if (stopDet) begin
        state    <= ST_IDLE;
        driveLow <= 1'b0;
      end else begin
        case (state)
          ST_HDR, ST_PTR, ST_WDATA: begin
            if (sclRise && bitCnt < 4'd8) begin
              shiftIn <= {shiftIn[6:0], sdaS};
              bitCnt  <= bitCnt + 4'd1;
            end else if (sclFall && bitCnt == 4'd8) begin
              bitCnt <= '0;
              case (state)
                ST_HDR: begin
                  if (shiftIn[7:1] == DEV_ADDR) begin
                    driveLow <= 1'b1;
                    rwBit    <= shiftIn[0];
                    state    <= ST_HDR_ACK;
                  end else begin
                    state <= ST_IDLE;
                  end
                end
                ST_PTR: begin
                  driveLow    <= 1'b1;
                  stb.setPtr  <= 1'b1;
                  stb.byteVal <= shiftIn;
                  state       <= ST_PTR_ACK;
                end
                default: begin
                  driveLow    <= 1'b1;
                  stb.wrEn    <= 1'b1;
                  stb.byteVal <= shiftIn;
                  state       <= ST_WDATA_ACK;
                end
              endcase
            end
          end
          ST_HDR_ACK: begin
            if (sclFall) begin
              if (rwBit) begin
                txShift   <= rdData;
                driveLow  <= ~rdData[7];
                stb.rdAdv <= 1'b1;
                bitCnt    <= '0;
                state     <= ST_TX;
              end else begin
                driveLow <= 1'b0;
                state    <= ST_PTR;
              end
            end
          end
          ST_PTR_ACK, ST_WDATA_ACK: begin
            if (sclFall) begin
              driveLow <= 1'b0;
              state    <= ST_WDATA;
            end
          end
          ST_TX: begin
            if (sclFall) begin
              if (bitCnt == 4'd7) begin
                driveLow <= 1'b0;
                state    <= ST_TX_ACK;
              end else begin
                txShift  <= {txShift[6:0], 1'b0};
                driveLow <= ~txShift[6];
                bitCnt   <= bitCnt + 4'd1;
              end
            end
          end
          ST_TX_ACK: begin
            if (sclRise) mAck <= ~sdaS;
            else if (sclFall) begin
              if (mAck) begin
                txShift   <= rdData;
                driveLow  <= ~rdData[7];
                stb.rdAdv <= 1'b1;
                bitCnt    <= '0;
                state     <= ST_TX;
              end else begin
                state <= ST_WAIT;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign sdaDrvLow = driveLow;

  AST_STOP_RELEASE: assert property (@(posedge clk) disable iff (!pwrDownN)
    stopDet |=> !sdaDrvLow); // R8
  AST_START_RESTART: assert property (@(posedge clk) disable iff (!pwrDownN)
    startDet |=> (!sdaDrvLow && state == ST_HDR)); // R11
  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!pwrDownN)
    $countones({stb.setPtr, stb.wrEn, stb.rdAdv}) <= 1); // R3

endmodule

// File: rtl/cfgI2cRegs.sv
module cfgI2cRegs
  import cfgI2cPkg::*;
#(
  parameter int NUM_REGS = 6,
  parameter int PTR_W    = 5
) (
  input  logic                  clk,
  input  logic                  pwrDownN,
  input  regStrobe_t            stb,
  output logic [7:0]            rdData,
  output logic [NUM_REGS*8-1:0] regFlat
);

  localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(NUM_REGS - 1);

  logic [PTR_W-1:0] ptr;

  always_ff @(posedge clk or negedge pwrDownN) begin
    if (!pwrDownN) ptr <= '0;
    else if (stb.setPtr) ptr <= stb.byteVal[PTR_W-1:0];
    else if (stb.wrEn || stb.rdAdv) ptr <= (ptr == LAST_PTR) ? '0 : ptr + 1'b1;
  end

  for (genvar i = 0; i < NUM_REGS; i++) begin : gReg
    logic [7:0] q;
    always_ff @(posedge clk or negedge pwrDownN) begin
      if (!pwrDownN) q <= regDefault(i);
      else if (stb.wrEn && ptr == PTR_W'(i)) q <= stb.byteVal & regMask(i);
    end
    assign regFlat[i*8 +: 8] = q;

    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!pwrDownN)
      (q & ~regMask(i)) == 8'h00); // R5
  end

  always_comb begin
    rdData = 8'h00;
    for (int i = 0; i < NUM_REGS; i++)
      if (ptr == PTR_W'(i)) rdData = regFlat[i*8 +: 8];
  end

  AST_PTR_WRAP: assert property (@(posedge clk) disable iff (!pwrDownN)
    ((stb.wrEn || stb.rdAdv) && !stb.setPtr && ptr == LAST_PTR) |=> ptr == '0); // R4
  AST_UNMAPPED_DISCARD: assert property (@(posedge clk) disable iff (!pwrDownN)
    (stb.wrEn && ptr > LAST_PTR) |=> $stable(regFlat)); // R9

endmodule

// File: rtl/i2cCfgRegs.sv
module i2cCfgRegs
  import cfgI2cPkg::*;
#(
  parameter int         NUM_REGS    = 6,
  parameter int         PTR_W       = 5,
  parameter logic [6:0] DEV_ADDR    = 7'h13,
  parameter int         SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  pwrDownN,
  input  logic                  sclIn,
  input  logic                  sdaIn,
  output logic                  sdaDrvLow,
  output logic [NUM_REGS*8-1:0] regOut
);

  regStrobe_t stb;
  logic [7:0] rdData;

  cfgI2cCtrl #(.DEV_ADDR(DEV_ADDR), .SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk(clk), .pwrDownN(pwrDownN), .sclIn(sclIn), .sdaIn(sdaIn),
    .rdData(rdData), .sdaDrvLow(sdaDrvLow), .stb(stb)
  );

  cfgI2cRegs #(.NUM_REGS(NUM_REGS), .PTR_W(PTR_W)) u_regs (
    .clk(clk), .pwrDownN(pwrDownN), .stb(stb),
    .rdData(rdData), .regFlat(regOut)
  );

endmodule

// File: tb/i2cCfgRegs_tb.sv
module i2cCfgRegs_tb;

  localparam int Q = 8;
  localparam logic [7:0] WR_HDR = 8'h26;
  localparam logic [7:0] RD_HDR = 8'h27;

  logic clk = 1'b0;
  logic pwrDownN = 1'b0;
  logic scl = 1'b1;
  logic tbSdaLow = 1'b0;
  logic sdaDrvLow;
  logic [47:0] regOut;
  wire sdaLine = !(sdaDrvLow || tbSdaLow);

  int errors = 0;
  int checks = 0;
  logic [7:0] model [6];

  always #4 clk = ~clk;

  i2cCfgRegs u_dut (
    .clk(clk), .pwrDownN(pwrDownN), .sclIn(scl), .sdaIn(sdaLine),
    .sdaDrvLow(sdaDrvLow), .regOut(regOut)
  );

  function automatic logic [7:0] bMask(input int i);
    case (i)
      0: return 8'hF3;
      1: return 8'hB5;
      5: return 8'h0F;
      default: return 8'hFF;
    endcase
  endfunction

  task automatic loadDefaults();
    model[0] = 8'h32; model[1] = 8'hA1; model[2] = 8'h3E;
    model[3] = 8'h3E; model[4] = 8'hFF; model[5] = 8'h09;
  endtask

  task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic checkRegs(input string req);
    logic [47:0] exp;
    for (int i = 0; i < 6; i++) exp[i*8 +: 8] = model[i];
    check(req, 64'(regOut), 64'(exp));
  endtask

  task automatic waitQ();
    repeat (Q) @(posedge clk);
    #1;
  endtask

  task automatic busStart();
    tbSdaLow = 1'b1; waitQ(); scl = 1'b0; waitQ();
  endtask

  task automatic busRestart();
    tbSdaLow = 1'b0; waitQ(); scl = 1'b1; waitQ();
    tbSdaLow = 1'b1; waitQ(); scl = 1'b0; waitQ();
  endtask

  task automatic busStop();
    tbSdaLow = 1'b1; waitQ(); scl = 1'b1; waitQ(); tbSdaLow = 1'b0; waitQ();
  endtask

  task automatic sendBits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      tbSdaLow = ~b[i]; waitQ(); scl = 1'b1; waitQ(); scl = 1'b0; waitQ();
    end
  endtask

  task automatic sendByte(input logic [7:0] b, output logic acked);
    sendBits(b, 8);
    tbSdaLow = 1'b0; waitQ(); scl = 1'b1; waitQ();
    acked = !sdaLine;
    scl = 1'b0; waitQ();
  endtask

  task automatic readByte(input logic masterAck, output logic [7:0] b);
    tbSdaLow = 1'b0;
    for (int i = 7; i >= 0; i--) begin
      waitQ(); scl = 1'b1; waitQ(); b[i] = sdaLine; scl = 1'b0;
    end
    tbSdaLow = masterAck; waitQ(); scl = 1'b1; waitQ(); scl = 1'b0; waitQ();
    tbSdaLow = 1'b0;
  endtask

  task automatic writeRegs(input logic [7:0] p, input logic [7:0] d [], input string req);
    logic a;
    busStart();
    sendByte(WR_HDR, a); check({req, " header ack"}, 64'(a), 64'd1);
    sendByte(p, a);      check({req, " pointer ack"}, 64'(a), 64'd1);
    for (int i = 0; i < d.size(); i++) begin
      int idx = (int'(p[4:0]) + i) % 6;
      sendByte(d[i], a);
      if (p[4:0] < 5'd6) model[idx] = d[i] & bMask(idx);
    end
    check({req, " last data ack"}, 64'(a), 64'd1);
    busStop();
  endtask

  task automatic tReset();
    loadDefaults();
    checkRegs("R1 defaults after power-down");
    check("R1 sda released", 64'(sdaDrvLow), 64'd0);
  endtask

  task automatic tWrongAddr();
    logic a;
    busStart();
    sendByte(8'h28, a); check("R2 foreign address not acked", 64'(a), 64'd0);
    sendByte(8'h00, a);
    sendByte(8'h5A, a);
    busStop();
    checkRegs("R2 foreign write changes nothing");
  endtask

  task automatic tWriteMasked();
    writeRegs(8'hE2, '{8'h55}, "R3");
    checkRegs("R3 pointer top bits ignored");
    writeRegs(8'h00, '{8'hFF, 8'hFF}, "R5");
    checkRegs("R5 reserved bits of 00h/01h stay 0, R4 auto-increment");
  endtask

  task automatic tWriteWrap();
    writeRegs(8'h04, '{8'h11, 8'hFF, 8'h33}, "R4");
    checkRegs("R4 write wraps 05h to 00h, R5 mask on 05h");
  endtask

  task automatic tCurrentRead();
    logic a; logic [7:0] b;
    busStart();
    sendByte(RD_HDR, a); check("R6 read header ack", 64'(a), 64'd1);
    readByte(1'b0, b);   check("R6 current read after write", 64'(b), 64'(model[1]));
    busStop();
    busStart();
    sendByte(RD_HDR, a);
    readByte(1'b0, b);   check("R6 current read after read", 64'(b), 64'(model[2]));
    busStop();
  endtask

  task automatic tRandomRead();
    logic a; logic [7:0] b; int rel;
    busStart();
    sendByte(WR_HDR, a);
    sendByte(8'h04, a);
    busRestart();
    sendByte(RD_HDR, a); check("R7 read header after restart acked", 64'(a), 64'd1);
    readByte(1'b1, b);   check("R7 random read 04h", 64'(b), 64'(model[4]));
    readByte(1'b1, b);   check("R8 continued read 05h", 64'(b), 64'(model[5]));
    readByte(1'b1, b);   check("R4 read wraps to 00h", 64'(b), 64'(model[0]));
    readByte(1'b0, b);   check("R8 last read 01h", 64'(b), 64'(model[1]));
    rel = 0;
    for (int i = 0; i < 9; i++) begin
      waitQ(); scl = 1'b1; waitQ();
      if (sdaLine) rel++;
      scl = 1'b0;
    end
    check("R8 released after not-acknowledge", 64'(rel), 64'd9);
    busStop();
  endtask

  task automatic tUnmapped();
    logic a; logic [7:0] b;
    busStart();
    sendByte(WR_HDR, a);
    sendByte(8'h07, a);
    sendByte(8'hAA, a); check("R9 unmapped write acked", 64'(a), 64'd1);
    busStop();
    checkRegs("R9 unmapped write discarded");
    busStart();
    sendByte(WR_HDR, a);
    sendByte(8'h1E, a);
    busRestart();
    sendByte(RD_HDR, a);
    readByte(1'b1, b); check("R9 read at 1Eh is 00h", 64'(b), 64'h00);
    readByte(1'b1, b); check("R9 read at 1Fh is 00h", 64'(b), 64'h00);
    readByte(1'b0, b); check("R9 pointer rolls 1Fh to 00h", 64'(b), 64'(model[0]));
    busStop();
  endtask

  task automatic tRestartMidByte();
    logic a;
    busStart();
    sendByte(WR_HDR, a);
    sendByte(8'h02, a);
    sendBits(8'hF0, 4);
    busRestart();
    sendByte(WR_HDR, a); check("R11 header after mid-byte start acked", 64'(a), 64'd1);
    sendByte(8'h03, a);
    sendByte(8'h77, a);
    busStop();
    model[3] = 8'h77;
    checkRegs("R11 abandoned byte not written");
  endtask

  task automatic tPowerDown();
    logic a;
    busStart();
    sendByte(WR_HDR, a);
    sendByte(8'h02, a);
    sendBits(8'hC3, 3);
    @(posedge clk); #3;
    pwrDownN = 1'b0;
    #1;
    loadDefaults();
    checkRegs("R10 immediate reload on power-down");
    check("R10 sda released during power-down", 64'(sdaDrvLow), 64'd0);
    waitQ();
    pwrDownN = 1'b1;
    busStop();
    writeRegs(8'h03, '{8'h44}, "R10");
    checkRegs("R10 writes work after power-down");
  endtask

  task automatic finishRun();
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: got timeout expected completion");
    finishRun();
  end

  initial begin
    repeat (4) @(posedge clk);
    #1;
    pwrDownN = 1'b1;
    waitQ();
    tReset();
    tWrongAddr();
    tWriteMasked();
    tWriteWrap();
    tCurrentRead();
    tRandomRead();
    tUnmapped();
    tRestartMidByte();
    tPowerDown();
    finishRun();
  end

endmodule